// File: doc/BRIEF.md
# Synchronous Long-Word Bus Read Master

This block sits between a processor's memory pipeline and a synchronous 32-bit external bus. It takes one request at a time over a valid/ready port and runs it on the bus. A request is either a single read of a byte, a 16-bit word or a 32-bit long word, or a 16-byte line read. For each bus cycle the block drives a one-clock start strobe, the address, the transfer size, the byte-lane selects and a transfer-in-progress flag. It then samples the slave's acknowledge and returns each captured word upstream with a beat index and a last flag.

Two options help slow or fast slaves. A programmed hold-off count makes the master ignore acknowledge for that many clocks after the start clock. A status output marks the first clock in which acknowledge is actually sampled. A line read normally runs as one burst of four data beats on a single address. If the slave answers the first beat with a burst-inhibit flag, the master fetches the other three words of the line with single long-word cycles of its own.

Top module: `lwbus_master`

## Requirements
- R1: A bus cycle begins with `bus_start` high for exactly one clock, the clock after the request is accepted. `bus_tip` is high from that clock until the cycle ends.
- R2: `bus_size` encodes 00 = long word, 01 = byte, 10 = 16-bit word, 11 = line. `bus_lanes[3]..[0]` select data bits 31:24, 23:16, 15:8 and 7:0. A byte at address bits 1:0 = n selects only lane 3-n. A word selects 4'b1100 when address bit 1 is 0 and 4'b0011 when it is 1. Long and line transfers select 4'b1111.
- R3: With `hold_cfg` = 0, `bus_samp` is high in the clock after `bus_start`. An acknowledge seen at the end of that clock ends the cycle. The word on `bus_data` at that edge appears on `rsp_data` with `rsp_valid` high during the next clock.
- R4: When acknowledge is low in a sampling clock, the master inserts a wait state and ignores the data. It samples again at every later edge, and `bus_samp` is not raised again within the same cycle.
- R5: With `hold_cfg` = N > 0, acknowledge is ignored in the first N clocks after `bus_start`. `bus_samp` rises in the clock after those N clocks, and acknowledge is first honoured at the end of that clock.
- R6: When a cycle ends and no further cycle of the same or a new request follows, `bus_tip` is low in the next clock. If another cycle starts at once, `bus_tip` stays high throughout.
- R7: A line read drives `bus_size` = 11 with a single `bus_start`. The address has bits 1:0 cleared and is held through all four beats. The hold-off applies to the first beat only. Beats 2 to 4 are sampled on every edge without raising `bus_samp`.
- R8: If `bus_noburst` is high together with acknowledge on the first beat of a line, the burst ends. The three remaining words are read with three single cycles of size 00. Each cycle uses address bits 3:2 = start + 1, + 2, + 3 modulo 4, upper bits kept and bits 1:0 zero, and each applies the hold-off.
- R9: Every captured word carries `rsp_beat`, the delivery order 0 to 3 within its request. `rsp_last` is high on beat 3 of a line and on the single word of a single read.
- R10: `req_ready` is high while no cycle is in progress. It is also high in the clock whose acknowledge ends the final cycle of a request, which lets a new request start with no idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | AW | Request byte address |
| req_size | input | 2 | Single read size (00 long, 01 byte, 10 word) |
| req_line | input | 1 | Request is a 16-byte line read |
| hold_cfg | input | HW | Acknowledge hold-off in clocks, 0 disables |
| bus_start | output | 1 | Start strobe, first clock of a cycle |
| bus_addr | output | AW | Bus address |
| bus_rnw | output | 1 | Read/write direction, always read |
| bus_size | output | 2 | Transfer size code |
| bus_lanes | output | 4 | Byte-lane selects |
| bus_tip | output | 1 | Transfer in progress |
| bus_samp | output | 1 | First acknowledge-sampling clock of a cycle |
| bus_ack | input | 1 | Slave transfer acknowledge |
| bus_noburst | input | 1 | Slave burst-inhibit |
| bus_data | input | 32 | Read data bus |
| rsp_valid | output | 1 | Captured word valid |
| rsp_data | output | 32 | Captured word |
| rsp_beat | output | 2 | Delivery index within the request |
| rsp_last | output | 1 | Final word of the request |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 3-bit hold-off field. It programs hold-off counts of 0, 1, 2, 3 and the maximum of 7. This covers immediate sampling, the shortest and longest hold-off windows, and a hold-off on a burst beat and on each fallback cycle. During every hold-off clock the slave is made to acknowledge with wrong data, so an early sample would show up as a wrong word or wrong timing. The line tests start from a middle word and from the last word of a block, which exercises the wrap of address bits 3:2 in the fallback path.

// File: rtl/lwbus_master.sv
module lwbus_master #(
  parameter int AW = 32,
  parameter int HW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_line,
  input  logic [HW-1:0] hold_cfg,
  output logic          bus_start,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rnw,
  output logic [1:0]    bus_size,
  output logic [3:0]    bus_lanes,
  output logic          bus_tip,
  output logic          bus_samp,
  input  logic          bus_ack,
  input  logic          bus_noburst,
  input  logic [31:0]   bus_data,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic [1:0]    rsp_beat,
  output logic          rsp_last
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  st_t           st;
  logic [HW-1:0] hold;
  logic          seen;
  logic [1:0]    beat;
  logic          line;
  logic          fb;
  logic [AW-1:0] base;
  logic [1:0]    sz_q;

  logic open_w, term, fin, take;

  assign open_w = (st == S_DATA) && (hold == '0);
  assign term   = open_w && bus_ack;
  assign fin    = term && (!line || beat == 2'd3);

  assign req_ready = (st == S_IDLE) || fin;
  assign take      = req_valid && req_ready;

  assign bus_start = (st == S_ADDR);
  assign bus_tip   = (st != S_IDLE);
  assign bus_samp  = open_w && !seen;
  assign bus_rnw   = 1'b1;

  assign bus_size = line ? (fb ? 2'b00 : 2'b11) : sz_q;
  assign bus_addr = line ? {base[AW-1:4], base[3:2] + (fb ? beat : 2'd0), 2'b00} : base;

  always_comb begin
    case (bus_size)
      2'b01:   bus_lanes = 4'b1000 >> base[1:0];
      2'b10:   bus_lanes = base[1] ? 4'b0011 : 4'b1100;
      default: bus_lanes = 4'b1111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      hold      <= '0;
      seen      <= 1'b0;
      beat      <= 2'd0;
      line      <= 1'b0;
      fb        <= 1'b0;
      base      <= '0;
      sz_q      <= 2'b00;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_beat  <= 2'd0;
      rsp_last  <= 1'b0;
    end else begin
      rsp_valid <= term;
      if (term) begin
        rsp_data <= bus_data;
        rsp_beat <= beat;
        rsp_last <= !line || beat == 2'd3;
      end

      if (st == S_ADDR) begin
        st   <= S_DATA;
        hold <= hold_cfg;
        seen <= 1'b0;
      end else if (st == S_DATA) begin
        if (hold != '0) hold <= hold - HW'(1);
        if (open_w) seen <= 1'b1;
        if (term) begin
          if (fin) begin
            st <= S_IDLE;
          end else begin
            beat <= beat + 2'd1;
            if (fb || (beat == 2'd0 && bus_noburst)) begin
              fb <= 1'b1;
              st <= S_ADDR;
            end
          end
        end
      end

      if (take) begin
        st   <= S_ADDR;
        base <= req_addr;
        sz_q <= req_line ? 2'b00 : req_size;
        line <= req_line;
        fb   <= 1'b0;
        beat <= 2'd0;
      end
    end
  end

endmodule

// File: rtl/lwbus_master_chk.sv
module lwbus_master_chk #(
  parameter int AW = 32,
  parameter int HW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] hold_cfg,
  input logic          bus_start,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic [3:0]    bus_lanes,
  input logic          bus_tip,
  input logic          bus_samp,
  input logic          bus_ack,
  input logic          rsp_valid,
  input logic [1:0]    rsp_beat,
  input logic          rsp_last
);

  p_start_one_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start && bus_tip);

  p_byte_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tip && bus_size == 2'b01 |-> $countones(bus_lanes) == 1);

  p_samp_c2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start && hold_cfg == '0 |=> bus_samp);

  p_rsp_needs_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_ack));

  p_samp_in_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_samp |-> bus_tip && !bus_start);

  p_addr_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tip && !bus_start |-> $stable(bus_addr));

  p_last_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_last && $past(bus_size) == 2'b11 |-> rsp_beat == 2'd3);

endmodule

bind lwbus_master lwbus_master_chk #(.AW(AW), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_cfg(hold_cfg), .bus_start(bus_start),
  .bus_addr(bus_addr), .bus_size(bus_size), .bus_lanes(bus_lanes),
  .bus_tip(bus_tip), .bus_samp(bus_samp), .bus_ack(bus_ack),
  .rsp_valid(rsp_valid), .rsp_beat(rsp_beat), .rsp_last(rsp_last)
);

// File: tb/lwbus_master_tb.sv
`timescale 1ns/1ps
module lwbus_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_line = 1'b0;
  logic [2:0]  hold_cfg = '0;
  logic        bus_start, bus_rnw, bus_tip, bus_samp;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic [3:0]  bus_lanes;
  logic        bus_ack = 1'b0;
  logic        bus_noburst = 1'b0;
  logic [31:0] bus_data = '0;
  logic        rsp_valid, rsp_last;
  logic [31:0] rsp_data;
  logic [1:0]  rsp_beat;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  lwbus_master u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_line(req_line),
    .hold_cfg(hold_cfg), .bus_start(bus_start), .bus_addr(bus_addr),
    .bus_rnw(bus_rnw), .bus_size(bus_size), .bus_lanes(bus_lanes),
    .bus_tip(bus_tip), .bus_samp(bus_samp), .bus_ack(bus_ack),
    .bus_noburst(bus_noburst), .bus_data(bus_data), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_beat(rsp_beat), .rsp_last(rsp_last)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic hold_phase(input logic [2:0] hd, input logic [31:0] junk);
    for (int k = 0; k < int'(hd); k++) begin
      chk("R5 samp low in hold", {31'd0, bus_samp}, 32'd0);
      bus_ack = 1'b1;
      bus_data = junk;
      step();
      chk("R5 ack ignored in hold", {31'd0, rsp_valid}, 32'd0);
    end
    bus_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 start low after reset", {31'd0, bus_start}, 32'd0);
    chk("R6 tip low after reset", {31'd0, bus_tip}, 32'd0);
    chk("R9 no rsp after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R10 ready after reset", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_single(input logic [31:0] a, input logic [1:0] sz, input logic [2:0] hd,
                          input int waits, input logic [31:0] d, input logic [3:0] lanes);
    hold_cfg = hd;
    req_addr = a; req_size = sz; req_line = 1'b0; req_valid = 1'b1;
    #1;
    chk("R10 ready idle", {31'd0, req_ready}, 32'd1);
    step();
    req_valid = 1'b0;
    chk("R1 start", {31'd0, bus_start}, 32'd1);
    chk("R1 tip", {31'd0, bus_tip}, 32'd1);
    chk("R2 lanes", {28'd0, bus_lanes}, {28'd0, lanes});
    chk("R2 size", {30'd0, bus_size}, {30'd0, sz});
    chk("R2 addr", bus_addr, a);
    step();
    chk("R1 start one clock", {31'd0, bus_start}, 32'd0);
    hold_phase(hd, ~d);
    chk("R3 R5 samp", {31'd0, bus_samp}, 32'd1);
    for (int w = 0; w < waits; w++) begin
      bus_ack = 1'b0;
      bus_data = ~d;
      step();
      chk("R4 wait no rsp", {31'd0, rsp_valid}, 32'd0);
      chk("R4 samp once", {31'd0, bus_samp}, 32'd0);
      chk("R4 tip in wait", {31'd0, bus_tip}, 32'd1);
    end
    bus_ack = 1'b1;
    bus_data = d;
    #1;
    chk("R10 ready at end", {31'd0, req_ready}, 32'd1);
    step();
    bus_ack = 1'b0;
    chk("R3 rsp valid", {31'd0, rsp_valid}, 32'd1);
    chk("R3 rsp data", rsp_data, d);
    chk("R9 beat", {30'd0, rsp_beat}, 32'd0);
    chk("R9 last single", {31'd0, rsp_last}, 32'd1);
    chk("R6 tip drop", {31'd0, bus_tip}, 32'd0);
  endtask

  task automatic t_line(input logic [31:0] a, input logic [2:0] hd, input bit inh,
                        input logic [31:0] d0);
    logic [31:0] la;
    la = {a[31:2], 2'b00};
    hold_cfg = hd;
    req_addr = a; req_size = 2'b00; req_line = 1'b1; req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    chk("R7 start", {31'd0, bus_start}, 32'd1);
    chk("R7 size line", {30'd0, bus_size}, 32'd3);
    chk("R7 addr", bus_addr, la);
    chk("R2 lanes line", {28'd0, bus_lanes}, 32'hf);
    step();
    hold_phase(hd, 32'hdead0000);
    chk("R5 samp beat0", {31'd0, bus_samp}, 32'd1);
    bus_ack = 1'b1; bus_noburst = inh; bus_data = d0;
    #1;
    chk("R10 not ready mid line", {31'd0, req_ready}, 32'd0);
    step();
    bus_noburst = 1'b0;
    chk("R9 rsp beat0", {31'd0, rsp_valid}, 32'd1);
    chk("R9 data beat0", rsp_data, d0);
    chk("R9 beat idx0", {30'd0, rsp_beat}, 32'd0);
    chk("R9 not last0", {31'd0, rsp_last}, 32'd0);
    if (!inh) begin
      for (int k = 1; k < 4; k++) begin
        chk("R7 no restart", {31'd0, bus_start}, 32'd0);
        chk("R7 no samp later beat", {31'd0, bus_samp}, 32'd0);
        chk("R7 addr held", bus_addr, la);
        bus_ack = 1'b1; bus_data = d0 + k;
        step();
        chk("R7 beat data", rsp_data, d0 + k);
        chk("R9 beat idx", {30'd0, rsp_beat}, k);
        chk("R9 last", {31'd0, rsp_last}, {31'd0, k == 3});
      end
      bus_ack = 1'b0;
    end else begin
      bus_ack = 1'b0;
      for (int k = 1; k < 4; k++) begin
        chk("R8 fallback start", {31'd0, bus_start}, 32'd1);
        chk("R6 tip kept", {31'd0, bus_tip}, 32'd1);
        chk("R8 size long", {30'd0, bus_size}, 32'd0);
        chk("R8 addr step", bus_addr, {a[31:4], 2'(a[3:2] + 2'(k)), 2'b00});
        step();
        hold_phase(hd, 32'hbad00000);
        chk("R8 samp each", {31'd0, bus_samp}, 32'd1);
        bus_ack = 1'b1; bus_data = d0 + k;
        step();
        bus_ack = 1'b0;
        chk("R8 rsp", {31'd0, rsp_valid}, 32'd1);
        chk("R8 data", rsp_data, d0 + k);
        chk("R9 beat idx fb", {30'd0, rsp_beat}, k);
        chk("R9 last fb", {31'd0, rsp_last}, {31'd0, k == 3});
      end
    end
    chk("R6 tip drop line", {31'd0, bus_tip}, 32'd0);
    req_line = 1'b0;
  endtask

  task automatic t_b2b();
    hold_cfg = 3'd0;
    req_addr = 32'h100; req_size = 2'b00; req_line = 1'b0; req_valid = 1'b1;
    step();
    req_addr = 32'h206; req_size = 2'b01;
    #1;
    chk("R10 ready low in start", {31'd0, req_ready}, 32'd0);
    step();
    #1;
    chk("R10 ready low waiting", {31'd0, req_ready}, 32'd0);
    bus_ack = 1'b1; bus_data = 32'h11112222;
    #1;
    chk("R10 ready at term", {31'd0, req_ready}, 32'd1);
    step();
    req_valid = 1'b0; bus_ack = 1'b0;
    chk("R6 rsp first", rsp_data, 32'h11112222);
    chk("R6 tip stays", {31'd0, bus_tip}, 32'd1);
    chk("R1 second start", {31'd0, bus_start}, 32'd1);
    chk("R2 byte lane2", {28'd0, bus_lanes}, 32'h2);
    chk("R2 second addr", bus_addr, 32'h206);
    step();
    chk("R6 tip stays data", {31'd0, bus_tip}, 32'd1);
    chk("R3 samp second", {31'd0, bus_samp}, 32'd1);
    bus_ack = 1'b1; bus_data = 32'h33334444;
    step();
    bus_ack = 1'b0;
    chk("R3 rsp second", rsp_data, 32'h33334444);
    chk("R6 tip drop b2b", {31'd0, bus_tip}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_single(32'h0000_0020, 2'b00, 3'd0, 0, 32'hcafe0001, 4'b1111);
    t_single(32'h0000_0013, 2'b01, 3'd0, 2, 32'h000000a5, 4'b0001);
    t_single(32'h0000_0012, 2'b10, 3'd3, 1, 32'h0000beef, 4'b0011);
    t_single(32'h0000_0040, 2'b00, 3'd7, 0, 32'h12345678, 4'b1111);
    t_line(32'h0000_0048, 3'd0, 1'b0, 32'ha0000000);
    t_line(32'h0000_0084, 3'd2, 1'b0, 32'hb0000000);
    t_line(32'h0000_00cc, 3'd1, 1'b1, 32'hc0000000);
    t_b2b();
    repeat (2) step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule